// File: doc/BRIEF.md
# Line Standard and Field Detector

This block watches the sync strobes of a decoded video stream. It counts the line strobes that fall between two field-start strobes. Each finished field is sorted into the 525-line family or the 625-line family by a single line-count threshold. A format flag follows that sorting only after a long run of fields has agreed. This keeps a noisy or switching source from toggling the reported standard. The block also reports the parity of the field now being decoded, taken from an odd/even indicator at each field start.

Beside these live flags sit two sticky error flags, one for luma overflow and one for chroma overflow. Each sets on a one-cycle overflow event and stays set until software clears it through a write strobe with a bit mask. If an overflow arrives in the same cycle as the clear, the overflow wins. Reset is asynchronous and active-low. Inside the block its release passes through a two-flop synchronizer.

Top module: `vstd_detect`

## Requirements
- R1: While reset is asserted, and until the first field has been classified, every output (format, field parity, both overflow flags) reads 0.
- R2: A field-start strobe closes the current field with the number of line strobes seen since the previous field start. A line strobe in the same cycle as the field start is counted in the new field, so no line is lost.
- R3: A closed field with fewer than 288 lines is classed 525-family (format value 0). A field with 288 lines or more is classed 625-family (format value 1).
- R4: The first field start after reset only opens counting. Lines seen before it are never classified.
- R5: The format output takes a field's class only when that field completes a run of 32 consecutive classified fields of the same class. The change appears two clock cycles after the field start that closes the 32nd field.
- R6: A classified field whose class differs from the previous classified field restarts the agreement run at 1.
- R7: The field-parity output takes the odd/even input (0 odd, 1 even) in the cycle after each field start. It holds that value until the next field start, whatever the input does in between.
- R8: Overflow input bit luma (flag bit 0) and chroma (flag bit 1) set their flag one cycle after the event. Each flag then holds until it is cleared.
- R9: A clear write (clear strobe high, mask bit 0 for luma, mask bit 1 for chroma) drops the masked flags. An overflow event in the same cycle as the clear keeps its flag set.
- R10: A clear write whose mask bit is 0 leaves that flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_stb_i | input | 1 | One-cycle strobe per detected line |
| field_stb_i | input | 1 | One-cycle strobe at each field start |
| even_i | input | 1 | Field parity indicator, sampled at field start (1 = even) |
| ovf_luma_i | input | 1 | One-cycle luma converter overflow event |
| ovf_chroma_i | input | 1 | One-cycle chroma converter overflow event |
| clr_wr_i | input | 1 | Write strobe that clears the sticky flags |
| clr_mask_i | input | 2 | Flags to clear: bit 0 luma, bit 1 chroma |
| fmt625_o | output | 1 | Line-standard flag: 0 = 525 family, 1 = 625 family |
| even_field_o | output | 1 | Parity of the field being decoded: 0 odd, 1 even |
| ovf_luma_o | output | 1 | Sticky luma overflow flag |
| ovf_chroma_o | output | 1 | Sticky chroma overflow flag |

## Verification
A wrong agreement counter or line counter shows up at the format port only at the end of a run. The flag flips one or more fields too early, or it never flips. The bench therefore checks the flag after every single field across long runs, near the 288-line boundary, with coincident strobes and with a partial field before the first field start. A parity or sticky-flag fault is visible within two cycles of the stimulus, and every field and every clear write is checked.

// File: rtl/vstd_pkg.sv
package vstd_pkg;
  typedef enum logic {
    FMT_525 = 1'b0,
    FMT_625 = 1'b1
  } fmt_e;
endpackage

// File: rtl/vstd_line_count.sv
module vstd_line_count
  import vstd_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int SPLIT = 288
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_stb_i,
  input  logic field_stb_i,
  output logic fin_stb_o,
  output fmt_e fin_cls_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] Split  = CNT_W'(SPLIT);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             armed_q, armed_n;
  logic             fin_q, fin_n;
  fmt_e             cls_q, cls_n;
  logic             cnt_en, cls_en;

  always_comb begin
    cnt_en  = field_stb_i | line_stb_i;
    cls_en  = field_stb_i & armed_q;
    armed_n = armed_q | field_stb_i;
    fin_n   = field_stb_i & armed_q;
    cls_n   = (cnt_q >= Split) ? FMT_625 : FMT_525;
    if (field_stb_i) begin
      cnt_n = line_stb_i ? CNT_W'(1) : '0;
    end else if (cnt_q != CntMax) begin
      cnt_n = cnt_q + CNT_W'(1);
    end else begin
      cnt_n = cnt_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      fin_q   <= 1'b0;
      cls_q   <= FMT_525;
    end else begin
      fin_q   <= fin_n;
      armed_q <= armed_n;
      if (cnt_en) cnt_q <= cnt_n;
      if (cls_en) cls_q <= cls_n;
    end
  end

  assign fin_stb_o = fin_q;
  assign fin_cls_o = cls_q;
endmodule

// File: rtl/vstd_persist.sv
module vstd_persist
  import vstd_pkg::*;
#(
  parameter int PERSIST = 32,
  localparam int RUN_W = $clog2(PERSIST + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fin_stb_i,
  input  fmt_e             fin_cls_i,
  output fmt_e             fmt_o,
  output logic [RUN_W-1:0] run_o
);
  localparam logic [RUN_W-1:0] RunMax = RUN_W'(PERSIST);

  fmt_e             prev_q, fmt_q, fmt_n;
  logic             have_q;
  logic [RUN_W-1:0] run_q, run_n;
  logic             match;

  always_comb begin
    match = have_q && (fin_cls_i == prev_q);
    if (!match)               run_n = RUN_W'(1);
    else if (run_q != RunMax) run_n = run_q + RUN_W'(1);
    else                      run_n = run_q;
    fmt_n = (run_n == RunMax) ? fin_cls_i : fmt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= FMT_525;
      fmt_q  <= FMT_525;
      have_q <= 1'b0;
      run_q  <= '0;
    end else if (fin_stb_i) begin
      prev_q <= fin_cls_i;
      fmt_q  <= fmt_n;
      have_q <= 1'b1;
      run_q  <= run_n;
    end
  end

  assign fmt_o = fmt_q;
  assign run_o = run_q;
endmodule

// File: rtl/vstd_sticky.sv
module vstd_sticky #(
  parameter int NBITS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NBITS-1:0] set_i,
  input  logic             clr_wr_i,
  input  logic [NBITS-1:0] clr_mask_i,
  output logic [NBITS-1:0] flag_o
);
  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    logic flag_q, flag_n, flag_en;
    always_comb begin
      flag_en = set_i[b] | (clr_wr_i & clr_mask_i[b]);
      flag_n  = set_i[b];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      flag_q <= 1'b0;
      else if (flag_en) flag_q <= flag_n;
    end
    assign flag_o[b] = flag_q;
  end
endmodule

// File: rtl/vstd_detect.sv
module vstd_detect
  import vstd_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int SPLIT   = 288,
  parameter int PERSIST = 32,
  localparam int RUN_W  = $clog2(PERSIST + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_stb_i,
  input  logic       field_stb_i,
  input  logic       even_i,
  input  logic       ovf_luma_i,
  input  logic       ovf_chroma_i,
  input  logic       clr_wr_i,
  input  logic [1:0] clr_mask_i,
  output logic       fmt625_o,
  output logic       even_field_o,
  output logic       ovf_luma_o,
  output logic       ovf_chroma_o
);
  logic [1:0]       rsync_q;
  logic             rst_core_n;
  logic             fin_stb;
  fmt_e             fin_cls;
  fmt_e             fmt;
  logic [RUN_W-1:0] run_cnt;
  logic             even_q;
  logic [1:0]       flags;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  vstd_line_count #(.CNT_W(CNT_W), .SPLIT(SPLIT)) u_count (
    .clk_i       (clk_i),
    .rst_ni      (rst_core_n),
    .line_stb_i  (line_stb_i),
    .field_stb_i (field_stb_i),
    .fin_stb_o   (fin_stb),
    .fin_cls_o   (fin_cls)
  );

  vstd_persist #(.PERSIST(PERSIST)) u_persist (
    .clk_i     (clk_i),
    .rst_ni    (rst_core_n),
    .fin_stb_i (fin_stb),
    .fin_cls_i (fin_cls),
    .fmt_o     (fmt),
    .run_o     (run_cnt)
  );

  vstd_sticky #(.NBITS(2)) u_sticky (
    .clk_i      (clk_i),
    .rst_ni     (rst_core_n),
    .set_i      ({ovf_chroma_i, ovf_luma_i}),
    .clr_wr_i   (clr_wr_i),
    .clr_mask_i (clr_mask_i),
    .flag_o     (flags)
  );

  always_ff @(posedge clk_i or negedge rst_core_n) begin
    if (!rst_core_n)      even_q <= 1'b0;
    else if (field_stb_i) even_q <= even_i;
  end

  assign fmt625_o     = (fmt == FMT_625);
  assign even_field_o = even_q;
  assign ovf_luma_o   = flags[0];
  assign ovf_chroma_o = flags[1];
endmodule

// File: rtl/vstd_detect_chk.sv
module vstd_detect_chk #(
  parameter int PERSIST = 32,
  localparam int RUN_W  = $clog2(PERSIST + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             field_stb_i,
  input logic             ovf_luma_i,
  input logic             ovf_chroma_i,
  input logic             clr_wr_i,
  input logic [1:0]       clr_mask_i,
  input logic             fmt625_o,
  input logic             even_field_o,
  input logic             ovf_luma_o,
  input logic             ovf_chroma_o,
  input logic             fin_stb,
  input logic [RUN_W-1:0] run_cnt
);
  // R5
  fmt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(fin_stb) |-> $stable(fmt625_o));
  // R5
  fmt_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt625_o != $past(fmt625_o)) |-> (run_cnt == RUN_W'(PERSIST)));
  // R7
  parity_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(field_stb_i) |-> $stable(even_field_o));
  // R8
  luma_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_luma_i |=> ovf_luma_o);
  // R8
  chroma_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_chroma_i |=> ovf_chroma_o);
  // R10
  luma_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_luma_o && !(clr_wr_i && clr_mask_i[0])) |=> ovf_luma_o);
  // R10
  chroma_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_chroma_o && !(clr_wr_i && clr_mask_i[1])) |=> ovf_chroma_o);
  // R9
  luma_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr_i && clr_mask_i[0] && !ovf_luma_i && $past(rst_ni)) |=> !ovf_luma_o);
endmodule

bind vstd_detect vstd_detect_chk #(.PERSIST(PERSIST)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .field_stb_i  (field_stb_i),
  .ovf_luma_i   (ovf_luma_i),
  .ovf_chroma_i (ovf_chroma_i),
  .clr_wr_i     (clr_wr_i),
  .clr_mask_i   (clr_mask_i),
  .fmt625_o     (fmt625_o),
  .even_field_o (even_field_o),
  .ovf_luma_o   (ovf_luma_o),
  .ovf_chroma_o (ovf_chroma_o),
  .fin_stb      (fin_stb),
  .run_cnt      (run_cnt)
);

// File: tb/vstd_detect_test.sv
module vstd_detect_test;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       line_stb_i, field_stb_i, even_i;
  logic       ovf_luma_i, ovf_chroma_i, clr_wr_i;
  logic [1:0] clr_mask_i;
  logic       fmt625_o, even_field_o, ovf_luma_o, ovf_chroma_o;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  // reference state derived from the requirements
  bit exp_fmt = 0, exp_even = 0, exp_luma = 0, exp_chroma = 0;
  bit started = 0, have_cls = 0, prev_cls = 0;
  int run = 0, prev_lines = 0;

  always #10 clk = ~clk;

  vstd_detect uut (
    .clk_i(clk), .rst_ni(rst_ni), .line_stb_i(line_stb_i), .field_stb_i(field_stb_i),
    .even_i(even_i), .ovf_luma_i(ovf_luma_i), .ovf_chroma_i(ovf_chroma_i),
    .clr_wr_i(clr_wr_i), .clr_mask_i(clr_mask_i), .fmt625_o(fmt625_o),
    .even_field_o(even_field_o), .ovf_luma_o(ovf_luma_o), .ovf_chroma_o(ovf_chroma_o)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(string tag);
    exp_q.push_back({exp_fmt, exp_even, exp_luma, exp_chroma});
    tag_q.push_back(tag);
  endtask

  // monitor: compares queued expectations shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (exp_q.size() > 0) begin
        logic [3:0] e;
        logic [3:0] a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {fmt625_o, even_field_o, ovf_luma_o, ovf_chroma_o};
        n_checks++;
        if (a !== e) begin
          n_fails++;
          $display("FAIL %s: {fmt,even,luma,chroma} actual %b expected %b at %0t", t, a, e, $time);
        end
      end
    end
  end

  // one field: start strobe, then a line strobe every cycle
  task automatic send_field(int lines, bit even, bit coin, string tag);
    if (started) begin
      bit c;
      c = (prev_lines >= 288);                       // R3
      if (have_cls && c == prev_cls) run = (run < 32) ? run + 1 : 32;
      else run = 1;                                  // R6
      prev_cls = c;
      have_cls = 1;
      if (run == 32) exp_fmt = c;                    // R5
    end
    started    = 1;                                  // R4
    prev_lines = lines + (coin ? 1 : 0);             // R2
    exp_even   = even;
    field_stb_i = 1'b1; even_i = even; line_stb_i = coin;
    tick();
    field_stb_i = 1'b0; even_i = ~even;              // R7: input moves, flag must hold
    for (int i = 0; i < lines; i++) begin
      line_stb_i = 1'b1;
      tick();
      if (i == 1) push(tag);
    end
    line_stb_i = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        n_fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
      end
    end
  end

  initial begin
    rst_ni = 1'b0; line_stb_i = 0; field_stb_i = 0; even_i = 0;
    ovf_luma_i = 0; ovf_chroma_i = 0; clr_wr_i = 0; clr_mask_i = 2'b00;
    tick(); tick();
    push("R1 in reset");
    tick();
    rst_ni = 1'b1;
    repeat (4) tick();
    push("R1 after reset");

    // R4: partial field of 300 lines before the first field start
    line_stb_i = 1'b1;
    repeat (300) tick();
    line_stb_i = 1'b0;

    // R5: run of 625-family fields
    for (int f = 0; f < 34; f++) send_field(312, f[0], 0, "R5 625 run");
    // R6: interrupted 525 run
    for (int f = 0; f < 20; f++) send_field(262, f[0], 0, "R6 525 before break");
    send_field(312, 1, 0, "R6 break field");
    for (int f = 0; f < 36; f++) send_field(262, f[0], 0, "R6 525 after break");
    // R2: 287 lines plus a coincident line make 288
    for (int f = 0; f < 34; f++) send_field(287, f[0], 1, "R2 coincident line");
    // R3: 287 lines fall in the 525 family
    for (int f = 0; f < 34; f++) send_field(287, f[0], 0, "R3 287 lines");
    field_stb_i = 1'b1; even_i = 1'b1;
    tick();
    field_stb_i = 1'b0; even_i = 1'b0;
    exp_even = 1;
    tick(); tick();
    push("R7 final field start");

    // sticky flags
    ovf_luma_i = 1; tick(); ovf_luma_i = 0; tick();
    exp_luma = 1; push("R8 luma set");
    clr_wr_i = 1; clr_mask_i = 2'b10; tick(); clr_wr_i = 0; tick();
    push("R10 chroma-only clear");
    ovf_chroma_i = 1; tick(); ovf_chroma_i = 0; tick();
    exp_chroma = 1; push("R8 chroma set");
    repeat (5) tick();
    push("R8 hold");
    clr_wr_i = 1; clr_mask_i = 2'b01; tick(); clr_wr_i = 0; tick();
    exp_luma = 0; push("R10 luma-only clear");
    ovf_luma_i = 1; clr_wr_i = 1; clr_mask_i = 2'b11; tick();
    ovf_luma_i = 0; clr_wr_i = 0; tick();
    exp_luma = 1; exp_chroma = 0; push("R9 overflow beats clear");
    clr_wr_i = 1; clr_mask_i = 2'b01; tick(); clr_wr_i = 0; tick();
    exp_luma = 0; push("R9 plain clear");

    repeat (4) tick();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule